// File: doc/BRIEF.md
# Flat-Panel Power Sequencer

This block switches a flat panel's supply enable and backlight enable in a safe order, with programmable waits between the steps. Software programs the step delays, a reference clock divider, a minimum off time and a port-select field through a small word-addressed register interface. It then raises or clears a single "panel wanted on" control bit. The sequencer does the rest and reports what it is doing in a status word.

One reference divider makes a common time base. Each base tick is one delay unit, intended as 100 µs. The minimum off time is counted in coarse units of `CYC_TICKS` base ticks, intended as 100 ms. Its field holds the unit count plus one, so a field value of 0 or 1 means no off time.

Changes to the control register are guarded by a 16-bit key in the upper half of the written word. A separate panel reset input can force a power-down when the control register asks for that.

Top module: `panel_pwr_seq`

Register word addresses (`addr`): 0 status (read only), 1 control, 2 on-timing, 3 off-timing, 4 divider.

## Requirements
- R1: Registers read back only their implemented bits. On-timing keeps bits 31:30 (port select), 28:16 (supply-to-ready wait) and 12:0 (ready-to-backlight wait). Off-timing keeps 28:16 (supply-off settle wait) and 12:0 (backlight-off-to-supply-off wait). Divider keeps 31:8 (reference divide count) and 4:0 (off-time field). Control reads {28'b0, override, backlight enable, power-down-on-reset, target on} in bits 3:0. Writes to status have no effect.
- R2: A control write changes the control register only when wdata[31:16] equals 16'hABCD. Any other key leaves control unchanged.
- R3: The `port_sel` output follows on-timing bits 31:30.
- R4: The base tick occurs once every `divide count` clock cycles, with 0 and 1 both meaning every cycle. All step waits are counted in base ticks.
- R5: On target on (control bit 0) the sequencer first waits out any remaining off time. It then raises `panel_vdd`, waits the supply-to-ready time and then the ready-to-backlight time. Status bits 29:28 read 1 during this whole climb.
- R6: When fully on, `panel_bl` equals control bit 2 (backlight enable), and it follows changes of that bit.
- R7: When target on clears, `panel_bl` drops first. `panel_vdd` drops after the backlight-off wait. Status bits 29:28 read 2 until the settle wait after supply-off has also elapsed, and then read 0.
- R8: At the end of a power-down, a divider off-time field F > 1 starts an off timer of (F-1)·CYC_TICKS ticks. Status bit 27 is high while it runs, and no power-up raises the supply before it expires.
- R9: An off-time field of 0 or 1 starts no off timer, and a following power-up proceeds at once.
- R10: Control bit 3 (override) drives `panel_vdd` high at once, independent of the sequence, and leaves `panel_bl` and progress untouched.
- R11: A `panel_rst` pulse while control bit 1 is set clears target on and override, which runs a normal power-down, and sets status bit 30. The next keyed control write clears bit 30. With control bit 1 clear, the pulse has no effect.
- R12: Status bit 31 is high exactly while the sequence rests in the fully-on state.
- R13: After reset, control and status read 0, both outputs are low, and the timing registers hold their parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| panel_rst | input | 1 | Panel reset request pulse |
| panel_vdd | output | 1 | Panel supply enable |
| panel_bl | output | 1 | Panel backlight enable |
| port_sel | output | 2 | Selected panel port |

## Verification
The assertions assume that registers are written only through the strobe and that `panel_rst` is a synchronous single-cycle pulse. They also assume the override bit is clear whenever the supply-rise ordering is judged, so that only the sequencer moves the supply. The stimulus writes registers one at a time on falling edges. It keeps the reference divider at 1 or 4, so that every wait lands in a known window. Each check is sampled well inside a window rather than on its edge.

// File: rtl/pps_pkg.sv
package pps_pkg;

   localparam int ADDR_W = 3;
   localparam int DATA_W = 32;

   localparam logic [ADDR_W-1:0] A_STAT   = 3'd0;
   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
   localparam logic [ADDR_W-1:0] A_ONTIM  = 3'd2;
   localparam logic [ADDR_W-1:0] A_OFFTIM = 3'd3;
   localparam logic [ADDR_W-1:0] A_DIV    = 3'd4;

   localparam int OFFCYC_FW = 5;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_CYC_WAIT,
      ST_UP_DLY,
      ST_BL_DLY,
      ST_ON,
      ST_BL_OFF,
      ST_DN_DLY
   } seq_state_e;

   typedef enum logic [1:0] {
      PRG_IDLE = 2'd0,
      PRG_UP   = 2'd1,
      PRG_DOWN = 2'd2
   } prog_e;

   typedef struct packed {
      logic ovr;
      logic bl_en;
      logic pd_rst;
      logic tgt;
   } ctrl_t;

endpackage

// File: rtl/pps_tick.sv
module pps_tick #(
   parameter int DIV_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] ref_div,
   output logic             tick
);
   logic [DIV_W-1:0] pre_cnt;

   always_comb begin
      if (ref_div <= DIV_W'(1)) tick = 1'b1;
      else                      tick = (pre_cnt >= ref_div - DIV_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_cnt <= '0;
      else if (tick) pre_cnt <= '0;
      else           pre_cnt <= pre_cnt + DIV_W'(1);
   end
endmodule

// File: rtl/pps_regs.sv
module pps_regs
   import pps_pkg::*;
#(
   parameter int          DLY_W       = 13,
   parameter int          DIV_W       = 24,
   parameter logic [15:0] KEY         = 16'hABCD,
   parameter int          DEF_UP      = 2100,
   parameter int          DEF_BL      = 1,
   parameter int          DEF_DN      = 5000,
   parameter int          DEF_BLOFF   = 500,
   parameter int          DEF_OFFCYC  = 7,
   parameter int          DEF_REF_DIV = 12500
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 panel_rst,
   output ctrl_t                ctrl,
   output logic                 rst_flag,
   output logic [1:0]           port_reg,
   output logic [DLY_W-1:0]     up_dly,
   output logic [DLY_W-1:0]     bl_dly,
   output logic [DLY_W-1:0]     dn_dly,
   output logic [DLY_W-1:0]     bloff_dly,
   output logic [DIV_W-1:0]     ref_div,
   output logic [OFFCYC_FW-1:0] offcyc
);
   logic key_ok;
   assign key_ok = (wdata[31:16] == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl      <= '0;
         rst_flag  <= 1'b0;
         port_reg  <= '0;
         up_dly    <= DLY_W'(DEF_UP);
         bl_dly    <= DLY_W'(DEF_BL);
         dn_dly    <= DLY_W'(DEF_DN);
         bloff_dly <= DLY_W'(DEF_BLOFF);
         ref_div   <= DIV_W'(DEF_REF_DIV);
         offcyc    <= OFFCYC_FW'(DEF_OFFCYC);
      end else begin
         if (wr_en) begin
            unique case (addr)
               A_CTRL: if (key_ok) begin
                  ctrl     <= ctrl_t'(wdata[3:0]);
                  rst_flag <= 1'b0;
               end
               A_ONTIM: begin
                  port_reg <= wdata[31:30];
                  up_dly   <= wdata[16 +: DLY_W];
                  bl_dly   <= wdata[0 +: DLY_W];
               end
               A_OFFTIM: begin
                  dn_dly    <= wdata[16 +: DLY_W];
                  bloff_dly <= wdata[0 +: DLY_W];
               end
               A_DIV: begin
                  ref_div <= wdata[8 +: DIV_W];
                  offcyc  <= wdata[OFFCYC_FW-1:0];
               end
               default: ;
            endcase
         end
         if (panel_rst && ctrl.pd_rst) begin
            ctrl.tgt <= 1'b0;
            ctrl.ovr <= 1'b0;
            rst_flag <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
   import pps_pkg::*;
#(
   parameter int DLY_W     = 13,
   parameter int CYC_TICKS = 1000,
   parameter int CYC_W     = 15
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 tgt,
   input  logic                 bl_en,
   input  logic [DLY_W-1:0]     up_dly,
   input  logic [DLY_W-1:0]     bl_dly,
   input  logic [DLY_W-1:0]     dn_dly,
   input  logic [DLY_W-1:0]     bloff_dly,
   input  logic [OFFCYC_FW-1:0] offcyc,
   output logic                 vdd_seq,
   output logic                 bl_out,
   output prog_e                prog,
   output logic                 enabled,
   output logic                 cyc_active
);
   seq_state_e       st;
   logic [DLY_W-1:0] cnt;
   logic [CYC_W-1:0] cyc_cnt;
   logic [CYC_W-1:0] cyc_load;
   logic             dn_done;

   always_comb begin
      if (offcyc > OFFCYC_FW'(1))
         cyc_load = CYC_W'(offcyc - OFFCYC_FW'(1)) * CYC_W'(CYC_TICKS);
      else
         cyc_load = '0;
   end

   assign dn_done = (st == ST_DN_DLY) && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_OFF;
         cnt <= '0;
      end else begin
         unique case (st)
            ST_OFF:
               if (tgt) st <= ST_CYC_WAIT;
            ST_CYC_WAIT:
               if (!tgt) st <= ST_OFF;
               else if (cyc_cnt == '0) begin
                  st  <= ST_UP_DLY;
                  cnt <= up_dly;
               end
            ST_UP_DLY, ST_BL_DLY:
               if (!tgt) begin
                  st  <= ST_BL_OFF;
                  cnt <= bloff_dly;
               end else if (cnt == '0) begin
                  if (st == ST_UP_DLY) begin
                     st  <= ST_BL_DLY;
                     cnt <= bl_dly;
                  end else begin
                     st <= ST_ON;
                  end
               end else if (tick) cnt <= cnt - DLY_W'(1);
            ST_ON:
               if (!tgt) begin
                  st  <= ST_BL_OFF;
                  cnt <= bloff_dly;
               end
            ST_BL_OFF:
               if (cnt == '0) begin
                  st  <= ST_DN_DLY;
                  cnt <= dn_dly;
               end else if (tick) cnt <= cnt - DLY_W'(1);
            ST_DN_DLY:
               if (cnt == '0) st <= ST_OFF;
               else if (tick) cnt <= cnt - DLY_W'(1);
            default: st <= ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cyc_cnt <= '0;
      else if (dn_done)                   cyc_cnt <= cyc_load;
      else if (tick && cyc_cnt != '0)     cyc_cnt <= cyc_cnt - CYC_W'(1);
   end

   always_comb begin
      vdd_seq    = (st == ST_UP_DLY) || (st == ST_BL_DLY) ||
                   (st == ST_ON)     || (st == ST_BL_OFF);
      bl_out     = (st == ST_ON) && bl_en;
      enabled    = (st == ST_ON);
      cyc_active = (cyc_cnt != '0);
      unique case (st)
         ST_CYC_WAIT, ST_UP_DLY, ST_BL_DLY: prog = PRG_UP;
         ST_BL_OFF, ST_DN_DLY:              prog = PRG_DOWN;
         default:                           prog = PRG_IDLE;
      endcase
   end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
   import pps_pkg::*;
#(
   parameter int          DLY_W        = 13,
   parameter int          DIV_W        = 24,
   parameter int          CYC_TICKS    = 1000,
   parameter bit          HAS_PORT_SEL = 1'b1,
   parameter logic [15:0] KEY          = 16'hABCD,
   parameter int          DEF_UP       = 2100,
   parameter int          DEF_BL       = 1,
   parameter int          DEF_DN       = 5000,
   parameter int          DEF_BLOFF    = 500,
   parameter int          DEF_OFFCYC   = 7,
   parameter int          DEF_REF_DIV  = 12500
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   input  logic        panel_rst,
   output logic        panel_vdd,
   output logic        panel_bl,
   output logic [1:0]  port_sel
);
   localparam int CYC_MAX = ((1 << OFFCYC_FW) - 2) * CYC_TICKS;
   localparam int CYC_W   = $clog2(CYC_MAX + 1);

   if (DLY_W < 4 || DLY_W > 13) begin : g_bad_dly
      $error("DLY_W must lie in 4..13");
   end
   if (DIV_W < 2 || DIV_W > 24) begin : g_bad_div
      $error("DIV_W must lie in 2..24");
   end
   if (CYC_TICKS < 1) begin : g_bad_cyc
      $error("CYC_TICKS must be positive");
   end

   ctrl_t                ctrl;
   logic                 rst_flag;
   logic [1:0]           port_reg;
   logic [DLY_W-1:0]     up_dly, bl_dly, dn_dly, bloff_dly;
   logic [DIV_W-1:0]     ref_div;
   logic [OFFCYC_FW-1:0] offcyc;
   logic                 tick;
   logic                 vdd_seq, bl_out, enabled, cyc_active;
   prog_e                prog;
   logic [1:0]           port_vis;

   pps_regs #(
      .DLY_W(DLY_W), .DIV_W(DIV_W), .KEY(KEY),
      .DEF_UP(DEF_UP), .DEF_BL(DEF_BL), .DEF_DN(DEF_DN),
      .DEF_BLOFF(DEF_BLOFF), .DEF_OFFCYC(DEF_OFFCYC), .DEF_REF_DIV(DEF_REF_DIV)
   ) u_regs (
      .clk, .rst_n, .wr_en, .addr, .wdata, .panel_rst,
      .ctrl, .rst_flag, .port_reg, .up_dly, .bl_dly, .dn_dly,
      .bloff_dly, .ref_div, .offcyc
   );

   pps_tick #(.DIV_W(DIV_W)) u_tick (
      .clk, .rst_n, .ref_div, .tick
   );

   pps_fsm #(.DLY_W(DLY_W), .CYC_TICKS(CYC_TICKS), .CYC_W(CYC_W)) u_fsm (
      .clk, .rst_n, .tick,
      .tgt(ctrl.tgt), .bl_en(ctrl.bl_en),
      .up_dly, .bl_dly, .dn_dly, .bloff_dly, .offcyc,
      .vdd_seq, .bl_out, .prog, .enabled, .cyc_active
   );

   if (HAS_PORT_SEL) begin : g_port
      assign port_vis = port_reg;
   end else begin : g_noport
      logic unused_port;
      assign unused_port = ^port_reg;
      assign port_vis    = 2'b00;
   end

   assign port_sel  = port_vis;
   assign panel_vdd = vdd_seq | ctrl.ovr;
   assign panel_bl  = bl_out;

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_STAT:   rdata = {enabled, rst_flag, prog, cyc_active, 27'b0};
         A_CTRL:   rdata = {28'b0, ctrl};
         A_ONTIM:  begin
            rdata[31:30]        = port_vis;
            rdata[16 +: DLY_W]  = up_dly;
            rdata[0 +: DLY_W]   = bl_dly;
         end
         A_OFFTIM: begin
            rdata[16 +: DLY_W]  = dn_dly;
            rdata[0 +: DLY_W]   = bloff_dly;
         end
         A_DIV:    begin
            rdata[8 +: DIV_W]         = ref_div;
            rdata[OFFCYC_FW-1:0]      = offcyc;
         end
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk
   import pps_pkg::*;
(
   input logic  clk,
   input logic  rst_n,
   input logic  panel_vdd,
   input logic  panel_bl,
   input logic  vdd_seq,
   input logic  ovr,
   input logic  enabled,
   input logic  cyc_active,
   input prog_e prog
);
   a_r5_bl_needs_vdd: assert property (@(posedge clk) disable iff (!rst_n)
      panel_bl |-> panel_vdd);

   a_r5_vdd_rise_in_climb: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vdd_seq) |-> (prog == PRG_UP));

   a_r6_bl_only_when_on: assert property (@(posedge clk) disable iff (!rst_n)
      panel_bl |-> enabled);

   a_r7_bl_gone_at_vdd_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vdd_seq) |-> !panel_bl);

   a_r8_no_rise_during_off_time: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(panel_vdd) && !ovr) |-> !$past(cyc_active));

   a_r12_on_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
      enabled |-> (prog == PRG_IDLE));

   a_r5_prog_legal: assert property (@(posedge clk) disable iff (!rst_n)
      prog != 2'd3);
endmodule

bind panel_pwr_seq panel_pwr_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .panel_vdd(panel_vdd), .panel_bl(panel_bl),
   .vdd_seq(vdd_seq), .ovr(ctrl.ovr), .enabled(enabled),
   .cyc_active(cyc_active), .prog(prog)
);

// File: tb/panel_pwr_seq_tb.sv
module panel_pwr_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        panel_rst = 1'b0;
   logic        panel_vdd, panel_bl;
   logic [1:0]  port_sel;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   panel_pwr_seq #(.CYC_TICKS(10)) u_dut (
      .clk, .rst_n, .wr_en, .addr, .wdata, .rdata,
      .panel_rst, .panel_vdd, .panel_bl, .port_sel
   );

   // {addr, write data, expected read back}
   localparam int NVEC = 10;
   localparam logic [66:0] VEC [NVEC] = '{
      {3'd2, 32'hFFFF_FFFF, 32'hDFFF_1FFF},   // R1 on-timing mask
      {3'd2, 32'h4014_0005, 32'h4014_0005},   // R1 port 1, up 20, bl 5
      {3'd3, 32'hFFFF_FFFF, 32'h1FFF_1FFF},   // R1 off-timing mask
      {3'd3, 32'h000A_0003, 32'h000A_0003},   // R1 settle 10, bl-off 3
      {3'd4, 32'hFFFF_FFFF, 32'hFFFF_FF1F},   // R1 divider mask
      {3'd4, 32'h0000_0103, 32'h0000_0103},   // R1 ref 1, off field 3
      {3'd1, 32'h1234_0005, 32'h0000_0000},   // R2 wrong key
      {3'd1, 32'hABCD_0002, 32'h0000_0002},   // R2 right key
      {3'd1, 32'h5555_0000, 32'h0000_0002},   // R2 wrong key keeps value
      {3'd1, 32'hABCD_0000, 32'h0000_0000}    // R2 right key clears
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_rst();
      @(negedge clk); panel_rst = 1'b1;
      @(negedge clk); panel_rst = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      cyc(3);
      // R13 reset state
      rd(3'd0, v); chk("R13 status", v, 32'h0);
      rd(3'd1, v); chk("R13 control", v, 32'h0);
      rd(3'd2, v); chk("R13 on-timing default", v, 32'h0834_0001);
      chk("R13 outputs", {30'b0, panel_vdd, panel_bl}, 32'h0);
      rst_n = 1'b1;
      cyc(2);

      for (int i = 0; i < NVEC; i++) begin
         wr(VEC[i][66:64], VEC[i][63:32]);
         rd(VEC[i][66:64], v);
         chk("R1/R2 vector", v, VEC[i][31:0]);
      end
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, v); chk("R1 status write ignored", v, 32'h0);
      chk("R3 port select", {30'b0, port_sel}, 32'h1);

      // R5 power-up climb with R12
      wr(3'd1, 32'hABCD_0005);
      cyc(1);
      rd(3'd0, v); chk("R5 progress up", v[29:28], 2'd1);
      cyc(4);
      chk("R5 supply on, backlight off", {30'b0, panel_vdd, panel_bl}, 32'h2);
      cyc(20);
      chk("R5 backlight still waiting", {31'b0, panel_bl}, 32'h0);
      cyc(10);
      chk("R5 backlight on", {31'b0, panel_bl}, 32'h1);
      rd(3'd0, v); chk("R12 enabled and idle", v, 32'h8000_0000);

      // R7 power-down order
      wr(3'd1, 32'hABCD_0004);
      cyc(2);
      chk("R7 backlight first", {30'b0, panel_vdd, panel_bl}, 32'h2);
      rd(3'd0, v); chk("R7 progress down", v[29:28], 2'd2);
      cyc(6);
      chk("R7 supply off", {31'b0, panel_vdd}, 32'h0);
      rd(3'd0, v); chk("R7 still down in settle", v[29:28], 2'd2);
      cyc(12);
      rd(3'd0, v); chk("R8 off timer running, idle", v, 32'h0800_0000);

      // R8 power-up held by off timer
      wr(3'd1, 32'hABCD_0005);
      cyc(8);
      chk("R8 supply held off", {31'b0, panel_vdd}, 32'h0);
      rd(3'd0, v); chk("R8 progress up while waiting", v[29:27], 3'b011);
      cyc(17);
      chk("R8 supply after off time", {31'b0, panel_vdd}, 32'h1);
      cyc(40);

      // R6 backlight follows enable while on
      wr(3'd1, 32'hABCD_0001);
      cyc(1);
      chk("R6 backlight follows enable low", {30'b0, panel_vdd, panel_bl}, 32'h2);
      wr(3'd1, 32'hABCD_0005);
      cyc(1);
      chk("R6 backlight follows enable high", {31'b0, panel_bl}, 32'h1);

      // R9 no off time with field 1
      wr(3'd4, 32'h0000_0101);
      wr(3'd1, 32'hABCD_0004);
      cyc(25);
      rd(3'd0, v); chk("R9 no off timer", v, 32'h0);
      wr(3'd1, 32'hABCD_0005);
      cyc(3);
      chk("R9 supply at once", {31'b0, panel_vdd}, 32'h1);
      cyc(40);

      // R11 panel reset without power-down-on-reset
      pulse_rst();
      cyc(10);
      chk("R11 pulse ignored outputs", {30'b0, panel_vdd, panel_bl}, 32'h3);
      rd(3'd1, v); chk("R11 pulse ignored control", v, 32'h5);
      rd(3'd0, v); chk("R11 no flag", v[30], 1'b0);

      // R11 forced power-down
      wr(3'd1, 32'hABCD_0007);
      pulse_rst();
      cyc(3);
      chk("R11 forced backlight off", {31'b0, panel_bl}, 32'h0);
      cyc(25);
      chk("R11 forced supply off", {31'b0, panel_vdd}, 32'h0);
      rd(3'd1, v); chk("R11 target cleared", v, 32'h6);
      rd(3'd0, v); chk("R11 flag set", v[30], 1'b1);
      wr(3'd1, 32'hABCD_0006);
      rd(3'd0, v); chk("R11 flag cleared by keyed write", v[30], 1'b0);

      // R10 override
      wr(3'd1, 32'hABCD_0008);
      cyc(1);
      chk("R10 override supply", {30'b0, panel_vdd, panel_bl}, 32'h2);
      rd(3'd0, v); chk("R10 progress untouched", v, 32'h0);
      wr(3'd1, 32'hABCD_0000);
      cyc(1);
      chk("R10 override released", {31'b0, panel_vdd}, 32'h0);

      // R4 divided base tick
      wr(3'd4, 32'h0000_0401);
      wr(3'd1, 32'hABCD_0005);
      cyc(70);
      chk("R4 slow tick backlight waiting", {30'b0, panel_vdd, panel_bl}, 32'h2);
      cyc(60);
      chk("R4 slow tick backlight on", {31'b0, panel_bl}, 32'h1);

      finish_run();
   end
endmodule